// File: doc/BRIEF.md
# Serial-Programmed DAC Code Controller

This block owns the eight-bit code word that sets the output of a current-steering DAC. The code can be written in one of three ways: a full serial load framed by a chip-select pin, single-direction stepping by clock pulses, or stepping up or down with the direction taken from the data pin. None of the three is chosen by a configuration register. The block watches the pin history after power-on and fixes its operating mode from it. The chosen mode holds until the next power-on reset.

The three external pins (chip select, serial clock, serial data) are asynchronous to the block. A fast system clock samples each of them through a two-stage synchronizer. Every edge the block reacts to is found on the synchronized copies. In the pulse modes only the upper six code bits count, so the word moves in steps of four and its two least significant bits stay zero. In serial mode the old code is shifted out on a data-out pin while the new one is shifted in.

Top module: `dac_code_ctrl`

## Requirements
- R1: While `rst_n` is low at a system clock edge, `code` becomes 8'h80, `mode` becomes 2'b00 (increment-only) and `dout_oe` becomes 0.
- R2: When the synchronized `cs_pin` is first seen low, `mode` becomes 2'b10 (serial) and keeps that value until reset. This takes priority over `din_pin` being low in the same cycle.
- R3: In increment-only mode, when `cs_pin` is high and the synchronized `din_pin` is seen low, `mode` becomes 2'b01 (up/down). It never returns to 2'b00 before reset.
- R4: In serial mode, a falling `cs_pin` sets `dout_oe` to 1 and puts bit 7 of the code held at that moment on `dout`.
- R5: While `cs_pin` is low, each rising `sclk_pin` shifts `din_pin` into a receive word, most significant bit first. Each falling `sclk_pin` moves `dout` on to the next lower bit of the old code.
- R6: A rising `cs_pin` copies the receive word into `code` and clears `dout_oe`.
- R7: In increment-only mode, each rising `sclk_pin` with `cs_pin` high adds one to `code[7:2]` and leaves `code[1:0]` at zero. 8'hFC steps to 8'h00, so 63 pulses lower the code by one step.
- R8: In up/down mode, each rising `sclk_pin` adds one to `code[7:2]` when `din_pin` is high and subtracts one when it is low. The count wraps at both ends: 8'hFC up gives 8'h00 and 8'h00 down gives 8'hFC.
- R9: The receive word is preset to the current code at the falling `cs_pin`. A frame with any number of clocks therefore loads the last eight bits of the sequence (old code followed by the received bits).
- R10: In serial mode, `sclk_pin` edges while `cs_pin` is high leave `code` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cs_pin | input | 1 | Chip select pin, asynchronous |
| sclk_pin | input | 1 | Serial or pulse clock pin, asynchronous |
| din_pin | input | 1 | Serial data or up/down direction pin, asynchronous |
| dout | output | 1 | Serial data out, valid while `dout_oe` is 1 |
| dout_oe | output | 1 | Output enable for `dout` (0 means high impedance) |
| code | output | 8 | DAC code word |
| mode | output | 2 | 00 increment-only, 01 up/down, 10 serial |

## Verification
The assertions assume that every pin level lasts at least three system clocks. This lets each synchronizer produce exactly one clean edge per pin transition. They also assume that a chip-select edge and a serial clock edge never reach the block in the same cycle. The stimulus changes one pin at a time on the falling system clock edge and holds each level for four or more system clocks. It sets the data pin several cycles before the clock rises that samples it.

// File: rtl/dac_ctrl_pkg.sv
// Package: shared mode encoding for the DAC code controller.
package dac_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_INC  = 2'b00,
        MODE_UPDN = 2'b01,
        MODE_SPI  = 2'b10
    } mode_e;
endpackage

// File: rtl/pin_sync.sv
// pin_sync: two-flop synchronizer for W asynchronous pins.
// Assumes: each pin is held stable long enough to be sampled; RST_VAL gives
// the idle level of each pin, so reset creates no false edge or mode change.
module pin_sync #(
    parameter int unsigned    W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1_q, s2_q;
        // Two-stage capture of one pin into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[g];
                s2_q <= RST_VAL[g];
            end else begin
                s1_q <= pin_i[g];
                s2_q <= s1_q;
            end
        end
        assign lvl_o[g] = s2_q;
    end
endmodule

// File: rtl/edge_detect.sv
// edge_detect: single-cycle rise and fall pulses on already synchronized levels.
// Assumes: inputs are synchronous to clk; RST_VAL matches the synchronizer reset.
module edge_detect #(
    parameter int unsigned  W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/mode_latch.sv
// mode_latch: fixes the operating mode from pin history after reset.
// Assumes: levels are synchronized. Chip select low has priority over data low.
module mode_latch
    import dac_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_lvl,
    input  logic  din_lvl,
    output mode_e mode_o
);
    mode_e mode_q;

    // Sticky mode selection: serial wins, up/down only from increment-only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode_q <= MODE_INC;
        else if (!cs_lvl)                        mode_q <= MODE_SPI;
        else if (mode_q == MODE_INC && !din_lvl) mode_q <= MODE_UPDN;
    end

    assign mode_o = mode_q;

    assert_cs_low_selects_spi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |=> mode_q == MODE_SPI);
    assert_spi_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_SPI |=> mode_q == MODE_SPI);
    assert_no_return_to_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_INC |=> mode_q != MODE_INC);
endmodule

// File: rtl/spi_shift.sv
// spi_shift: serial receive word and transmit word for chip-select framed transfers.
// Assumes: chip-select and serial clock edges never fall in the same cycle.
// The receive word is preset with the live code, so short frames are well defined.
module spi_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_lvl,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         din_lvl,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] rx_o,
    output logic         dout_o,
    output logic         oe_o
);
    logic [W-1:0] rx_q, tx_q;
    logic         oe_q;

    // Receive word: preset at frame start, shift data in on rising clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rx_q <= '0;
        else if (cs_fall)              rx_q <= code_i;
        else if (!cs_lvl && sclk_rise) rx_q <= {rx_q[W-2:0], din_lvl};
    end

    // Transmit word: old code captured at frame start, advanced on falling clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tx_q <= '0;
        else if (cs_fall)              tx_q <= code_i;
        else if (!cs_lvl && sclk_fall) tx_q <= {tx_q[W-2:0], 1'b0};
    end

    // Output enable follows the chip-select frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (cs_fall) oe_q <= 1'b1;
        else if (cs_rise) oe_q <= 1'b0;
    end

    assign rx_o   = rx_q;
    assign dout_o = tx_q[W-1];
    assign oe_o   = oe_q;

    assert_frame_start_drives_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> oe_q && dout_o == $past(code_i[W-1]));
    assert_frame_end_tristates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !oe_q);
endmodule

// File: rtl/dac_code_ctrl.sv
// dac_code_ctrl: DAC code register with serial, increment-only and up/down entry.
// Assumes: pins are asynchronous and each level lasts three or more clk cycles.
// Pulse modes step the upper CODE_W-STEP_LSB bits and force the low bits to zero.
module dac_code_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned STEP_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_pin,
    input  logic              sclk_pin,
    input  logic              din_pin,
    output logic              dout,
    output logic              dout_oe,
    output logic [CODE_W-1:0] code,
    output logic [1:0]        mode
);
    localparam int unsigned       HI_W     = CODE_W - STEP_LSB;
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    // Pin order in the vectors: {cs, sclk, din}; idle levels 1, 0, 1.
    logic [2:0] lvl;
    logic [1:0] rise, fall;
    logic       cs_lvl, sclk_lvl, din_lvl;
    mode_e      mode_q;
    logic [CODE_W-1:0] code_q, rx_word;
    logic [HI_W-1:0]   hi_next;
    logic              step_en;

    pin_sync #(.W(3), .RST_VAL(3'b101)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({cs_pin, sclk_pin, din_pin}), .lvl_o(lvl)
    );
    assign {cs_lvl, sclk_lvl, din_lvl} = lvl;

    edge_detect #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl_i({cs_lvl, sclk_lvl}), .rise_o(rise), .fall_o(fall)
    );

    mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .din_lvl(din_lvl), .mode_o(mode_q)
    );

    spi_shift #(.W(CODE_W)) u_spi (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl),
        .cs_fall(fall[1]), .cs_rise(rise[1]),
        .sclk_rise(rise[0]), .sclk_fall(fall[0]),
        .din_lvl(din_lvl), .code_i(code_q),
        .rx_o(rx_word), .dout_o(dout), .oe_o(dout_oe)
    );

    // Next value of the upper bits for a pulse step, direction from data pin.
    always_comb begin
        if (mode_q == MODE_UPDN && !din_lvl) hi_next = code_q[CODE_W-1:STEP_LSB] - 1'b1;
        else                                 hi_next = code_q[CODE_W-1:STEP_LSB] + 1'b1;
    end

    assign step_en = (mode_q != MODE_SPI) && cs_lvl && rise[0];

    // Code register: serial load at frame end, or a pulse step.
    always_ff @(posedge clk) begin
        if (!rst_n)                               code_q <= MID_CODE;
        else if (mode_q == MODE_SPI && rise[1])   code_q <= rx_word;
        else if (step_en)                         code_q <= {hi_next, {STEP_LSB{1'b0}}};
    end

    assign code = code_q;
    assign mode = mode_q;

    assert_inc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode_q == MODE_INC) |=>
        (code_q[CODE_W-1:STEP_LSB] == HI_W'($past(code_q[CODE_W-1:STEP_LSB]) + 1'b1)
         && code_q[STEP_LSB-1:0] == '0));
    assert_updn_down_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode_q == MODE_UPDN && !din_lvl) |=>
        (code_q[CODE_W-1:STEP_LSB] == HI_W'($past(code_q[CODE_W-1:STEP_LSB]) - 1'b1)));
    assert_spi_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SPI && !rise[1]) |=> $stable(code_q));
endmodule

// File: tb/sim_dac_code_ctrl.sv
module sim_dac_code_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_pin = 1'b1, sclk_pin = 1'b0, din_pin = 1'b1;
    logic       dout, dout_oe;
    logic [7:0] code;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] code;
        logic [1:0] mode;
        string      req;
    } exp_t;
    exp_t sb_q[$];
    exp_t cur;

    logic [7:0] m_code;
    logic [1:0] m_mode;

    always #4 clk = ~clk;

    dac_code_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_pin(cs_pin), .sclk_pin(sclk_pin),
        .din_pin(din_pin), .dout(dout), .dout_oe(dout_oe), .code(code), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare with the design outputs.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            chk({cur.req, " code"}, {24'd0, code}, {24'd0, cur.code});
            chk({cur.req, " mode"}, {30'd0, mode}, {30'd0, cur.mode});
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input string req);
        exp_t e;
        e.code = m_code; e.mode = m_mode; e.req = req;
        sb_q.push_back(e);
        wclk(2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_pin = 1'b1; sclk_pin = 1'b0; din_pin = 1'b1;
        wclk(4);
        rst_n = 1'b1;
        wclk(2);
        m_code = 8'h80; m_mode = 2'b00;
    endtask

    // One clock pulse with the data pin set first (pulse modes, or serial idle).
    task automatic pulse(input logic up, input string req);
        din_pin = up; wclk(4);
        sclk_pin = 1'b1; wclk(4);
        sclk_pin = 1'b0; wclk(6);
        if (m_mode == 2'b00)
            m_code = {m_code[7:2] + 6'd1, 2'b00};
        else if (m_mode == 2'b01)
            m_code = {up ? m_code[7:2] + 6'd1 : m_code[7:2] - 6'd1, 2'b00};
        push(req);
    endtask

    // Chip-select framed transfer of n bits, data sent from bit n-1 down.
    task automatic frame(input logic [15:0] data, input int n, input string req);
        logic [7:0] old, rx;
        old = m_code; rx = m_code;
        cs_pin = 1'b0; wclk(6);
        m_mode = 2'b10;
        chk("R4 oe", {31'd0, dout_oe}, 32'd1);
        chk("R4 dout msb", {31'd0, dout}, {31'd0, old[7]});
        for (int k = 0; k < n; k++) begin
            din_pin = data[n-1-k]; wclk(4);
            sclk_pin = 1'b1; wclk(4);
            sclk_pin = 1'b0; wclk(6);
            rx = {rx[6:0], data[n-1-k]};
            if (k < 7) chk("R5 dout bit", {31'd0, dout}, {31'd0, old[6-k]});
        end
        din_pin = 1'b1; wclk(4);
        cs_pin = 1'b1; wclk(6);
        chk("R6 oe off", {31'd0, dout_oe}, 32'd0);
        m_code = rx;
        push(req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        // Phase A: reset state, increment-only, then up/down.
        do_reset();
        chk("R1 oe", {31'd0, dout_oe}, 32'd0);
        push("R1 reset");
        pulse(1'b1, "R7 first step");
        for (int i = 0; i < 31; i++) pulse(1'b1, "R7 count up");
        chk("R7 wrapped to zero", {24'd0, m_code}, 32'd0);
        for (int i = 0; i < 63; i++) pulse(1'b1, "R7 63 pulses");
        chk("R7 one step down", {24'd0, m_code}, 32'hFC);
        din_pin = 1'b0; wclk(6);
        m_mode = 2'b01; push("R3 enter up/down");
        pulse(1'b0, "R8 down");
        pulse(1'b1, "R8 up");
        pulse(1'b1, "R8 wrap up");
        pulse(1'b0, "R8 wrap down");
        din_pin = 1'b1; wclk(6);
        push("R3 no return");
        frame(16'h0, 0, "R9 empty frame");

        // Phase B: serial mode with simultaneous low pins.
        do_reset();
        cs_pin = 1'b0; din_pin = 1'b0; wclk(6);
        m_mode = 2'b10; push("R2 priority");
        din_pin = 1'b1; wclk(2);
        cs_pin = 1'b1; wclk(6);
        push("R2 sticky");
        frame(16'h00A5, 8, "R6 load A5");
        frame(16'h003C, 8, "R6 load 3C");
        pulse(1'b1, "R10 clock with cs high");
        pulse(1'b0, "R10 clock with cs high");
        frame(16'h0005, 3, "R9 short frame");
        chk("R9 short value", {24'd0, m_code}, 32'hE5);
        frame(16'h035A, 10, "R9 long frame");
        chk("R9 long value", {24'd0, m_code}, 32'h5A);

        wait (sb_q.size() == 0);
        wclk(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule